// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the processor's program counter and works out, every cycle, the address the counter will take next. It always forms the sequential address, which is the current counter plus four. It compares two register operands to decide a conditional branch, and it builds two candidate targets. The branch target is a word offset taken relative to the sequential address. The jump target is a 26-bit word index placed inside the 256 MiB region that holds the sequential address.

A selector chooses among three sources of the next address. The sources are named `SRC_SEQ` (sequential), `SRC_BRANCH` (taken conditional branch) and `SRC_JUMP` (unconditional jump). Each cycle the selector makes one of three transitions. A decoded jump always moves it to `SRC_JUMP`. Otherwise a taken branch moves it to `SRC_BRANCH`. In every other case it goes to `SRC_SEQ`. The branch kinds are `BR_NONE`, `BR_EQ`, `BR_NE` and the reserved `BR_RSVD`. The counter register loads the selected address only when the write enable is high. A synchronous reset returns the counter to address zero.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `pc_q` to 0, which makes `pc_plus4` equal 4.
- R2: `pc_plus4` always equals `pc_q + 4`, modulo 2^32.
- R3: When `pc_we` is low and `rst` is low, `pc_q` keeps its value across the clock edge, whatever the other inputs are.
- R4: With `pc_we` high, `jump_en` low and no branch taken, `pc_q` loads `pc_q + 4`.
- R5: With `br_kind` = 2'b01 (branch if equal), the branch is taken exactly when `rs_val == rt_val`. When taken, `br_taken` is high and, with `pc_we` high and `jump_en` low, `pc_q` loads `pc_q + 4 + (sign-extended imm_off << 2)`.
- R6: With `br_kind` = 2'b10 (branch if not equal), the branch is taken exactly when `rs_val != rt_val`. When taken, the same target as in R5 is loaded.
- R7: With `br_kind` = 2'b00, `br_taken` is low. A branch whose condition fails gives the sequential address.
- R8: With `jump_en` high and `pc_we` high, `pc_q` loads `{pc_plus4[31:28], jump_field, 2'b00}`.
- R9: A jump has priority over a taken branch: the jump target is loaded. `br_taken` still reports the branch condition.
- R10: `br_kind` = 2'b11 is reserved. It never sets `br_taken` and behaves as no branch.
- R11: Branch offsets at the extremes, -32768 and +32767 instructions, give the correct target, wrapping modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_we | input | 1 | Counter write enable |
| br_kind | input | 2 | Branch kind: 00 none, 01 equal, 10 not equal, 11 reserved |
| jump_en | input | 1 | Unconditional jump decoded |
| imm_off | input | 16 | Signed branch offset in instructions |
| jump_field | input | 26 | Jump word index |
| rs_val | input | 32 | First compared register operand |
| rt_val | input | 32 | Second compared register operand |
| pc_q | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Sequential address, counter plus four |
| br_taken | output | 1 | Conditional branch condition holds for the decoded kind |

## Verification
The bench sweeps every combination of write enable, jump flag and all four branch kinds, each with equal and with differing operands. This separates a taken branch from an untaken one and shows that the reserved kind and a disabled write have no effect. The differing operands flip one bit at a time in several positions, so a comparator that checks only part of the word is caught. Offsets of zero, plus and minus one, and both extremes are used, and the jump fields include all-ones and alternating patterns. These show that sign extension, the two-bit shift and the upper-bit splice are right, and wrapping through address zero shows that the adder is modulo 2^32.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_EQ   = 2'b01,
        BR_NE   = 2'b10,
        BR_RSVD = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        SRC_SEQ    = 2'b00,
        SRC_BRANCH = 2'b01,
        SRC_JUMP   = 2'b10
    } pc_src_e;

endpackage

// File: rtl/npc_branch_eval.sv
module npc_branch_eval
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 16
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] opnd_a,
    input  logic [ADDR_W-1:0] opnd_b,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [OFFS_W-1:0] offset,
    output logic              taken,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFFS_W - 2;

    logic              same;
    logic [ADDR_W-1:0] byte_offs;

    assign same      = (opnd_a == opnd_b);
    assign byte_offs = {{EXT_W{offset[OFFS_W-1]}}, offset, 2'b00};
    assign target    = seq_addr + byte_offs;

    always_comb begin
        unique case (br_kind_e'(kind))
            BR_EQ:   taken = same;
            BR_NE:   taken = !same;
            BR_NONE: taken = 1'b0;
            BR_RSVD: taken = 1'b0;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_jump_form.sv
module npc_jump_form #(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 26
) (
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [TGT_W-1:0]  field,
    output logic [ADDR_W-1:0] target
);
    localparam int HI_W = ADDR_W - TGT_W - 2;

    assign target = {seq_addr[ADDR_W-1 -: HI_W], field, 2'b00};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 16,
    parameter int TGT_W  = 26,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pc_we,
    input  logic [1:0]        br_kind,
    input  logic              jump_en,
    input  logic [OFFS_W-1:0] imm_off,
    input  logic [TGT_W-1:0]  jump_field,
    input  logic [ADDR_W-1:0] rs_val,
    input  logic [ADDR_W-1:0] rt_val,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] pc_plus4,
    output logic              br_taken
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic [ADDR_W-1:0] br_target;
    logic [ADDR_W-1:0] jmp_target;
    logic [ADDR_W-1:0] pc_next;
    pc_src_e           src;

    assign pc_plus4 = pc_q + STEP;

    npc_branch_eval #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) br_i (
        .kind     (br_kind),
        .opnd_a   (rs_val),
        .opnd_b   (rt_val),
        .seq_addr (pc_plus4),
        .offset   (imm_off),
        .taken    (br_taken),
        .target   (br_target)
    );

    npc_jump_form #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) jmp_i (
        .seq_addr (pc_plus4),
        .field    (jump_field),
        .target   (jmp_target)
    );

    // source selection: jump outranks a taken branch
    always_comb begin
        if (jump_en)       src = SRC_JUMP;
        else if (br_taken) src = SRC_BRANCH;
        else               src = SRC_SEQ;
    end

    always_comb begin
        unique case (src)
            SRC_JUMP:   pc_next = jmp_target;
            SRC_BRANCH: pc_next = br_target;
            SRC_SEQ:    pc_next = pc_plus4;
            default:    pc_next = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        pc_q <= RESET_ADDR;
        else if (pc_we) pc_q <= pc_next;
    end

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> pc_q == RESET_ADDR);

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !pc_we |=> $stable(pc_q));

    a_r4_sequential: assert property (@(posedge clk) disable iff (rst)
        (pc_we && !jump_en && !br_taken) |=> pc_q == $past(pc_plus4));

    a_r5_eq_taken: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b01 && rs_val == rt_val) |-> br_taken);

    a_r6_ne_taken: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b10 && rs_val != rt_val) |-> br_taken);

    a_r7_none_idle: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b00) |-> !br_taken);

    a_r10_reserved_idle: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b11) |-> !br_taken);

    a_r8_jump_field: assert property (@(posedge clk) disable iff (rst)
        (pc_we && jump_en) |=>
            (pc_q[TGT_W+1:2] == $past(jump_field) && pc_q[1:0] == 2'b00));
endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pc_we = 1'b0;
    logic [1:0]  br_kind = 2'b00;
    logic        jump_en = 1'b0;
    logic [15:0] imm_off = '0;
    logic [25:0] jump_field = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc_q;
    logic [31:0] pc_plus4;
    logic        br_taken;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_unit dut_i (
        .clk(clk), .rst(rst), .pc_we(pc_we), .br_kind(br_kind),
        .jump_en(jump_en), .imm_off(imm_off), .jump_field(jump_field),
        .rs_val(rs_val), .rt_val(rt_val),
        .pc_q(pc_q), .pc_plus4(pc_plus4), .br_taken(br_taken)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, check combinational outputs, then the register
    task automatic step(input bit we, input bit j, input logic [1:0] kind,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] off, input logic [25:0] fld,
                        input string ovr_tag);
        bit          exp_tk;
        logic [31:0] seq, nxt;
        string       tk_tag, nx_tag;
        pc_we = we; jump_en = j; br_kind = kind;
        rs_val = a; rt_val = b; imm_off = off; jump_field = fld;
        #1;
        exp_tk = (kind == 2'd1 && a == b) || (kind == 2'd2 && a != b);
        tk_tag = (kind == 2'd1) ? "R5" : (kind == 2'd2) ? "R6" :
                 (kind == 2'd3) ? "R10" : "R7";
        check(br_taken == exp_tk, tk_tag, 32'(br_taken), 32'(exp_tk));
        seq = exp_pc + 32'd4;
        check(pc_plus4 == seq, "R2", pc_plus4, seq);
        if (!we)         begin nxt = exp_pc; nx_tag = "R3"; end
        else if (j)      begin
            nxt = (seq & 32'hF000_0000) | (32'(fld) * 32'd4);
            nx_tag = exp_tk ? "R9" : "R8";
        end
        else if (exp_tk) begin
            nxt = seq + 32'($signed(off)) * 32'd4;
            nx_tag = (kind == 2'd1) ? "R5" : "R6";
        end
        else begin
            nxt = seq;
            nx_tag = (kind == 2'd3) ? "R10" : (kind == 2'd0) ? "R4" : "R7";
        end
        if (ovr_tag != "") nx_tag = ovr_tag;
        @(posedge clk);
        @(negedge clk);
        check(pc_q == nxt, nx_tag, pc_q, nxt);
        exp_pc = nxt;
    endtask

    localparam logic [15:0] OFFS [6] = '{16'h0000, 16'h0001, 16'hFFFF,
                                         16'h7FFF, 16'h8000, 16'h0005};
    localparam logic [25:0] FLDS [6] = '{26'h0000000, 26'h3FFFFFF, 26'h1555555,
                                         26'h2AAAAAA, 26'h0000001, 26'h0123456};

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check(pc_q == 32'd0, "R1", pc_q, 32'd0);
        check(pc_plus4 == 32'd4, "R1", pc_plus4, 32'd4);
        exp_pc = 32'd0;

        // R11: extreme offsets from a known base
        step(1'b1, 1'b0, 2'b01, 32'h5, 32'h5, 16'h8000, '0, "R11");
        step(1'b1, 1'b0, 2'b10, 32'h5, 32'h6, 16'h7FFF, '0, "R11");

        for (int we = 0; we < 2; we++)
            for (int j = 0; j < 2; j++)
                for (int k = 0; k < 4; k++)
                    for (int e = 0; e < 2; e++)
                        for (int oi = 0; oi < 6; oi++) begin
                            logic [31:0] a, b;
                            a = 32'h1234_0000 + 32'(oi * 7);
                            b = (e == 1) ? a : (a ^ (32'h1 << (oi * 5 + 1)));
                            step(we[0], j[0], k[1:0], a, b, OFFS[oi], FLDS[oi], "");
                        end

        // R1: reset mid-run returns to zero
        rst = 1'b1; pc_we = 1'b1;
        @(posedge clk); @(negedge clk);
        check(pc_q == 32'd0, "R1", pc_q, 32'd0);
        rst = 1'b0; exp_pc = 32'd0;
        step(1'b1, 1'b0, 2'b00, 32'h0, 32'h0, 16'h0, '0, "R4");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule